// File: doc/BRIEF.md
# Erase Region Sector Locator

This block turns a byte offset inside a flash array into the number of the erase sector that holds it. It also reports that sector's size and the sector-aligned base address. The array may be built from up to four erase regions that sit back to back from offset zero. Each region has its own block count and its own power-of-two sector size. The layout is fixed by parameters and is checked when the design is elaborated. The lookup is purely combinational, so a command decoder can present an offset and use the result in the same cycle.

Next to the locator sits a register of pending-erase flags with one bit per sector. A one-cycle mark pulse flags the sector that the current offset falls in. A one-cycle clear pulse drops every flag at once, which is what happens when an erase finishes. The flag of the looked-up sector is always visible on an output. This lets a controller that is holding an erase in suspension refuse reads or programs aimed at a sector that is still waiting to be erased.

Top module: `sector_locator`

## Requirements
- R1: Regions are placed contiguously from offset 0 in index order. The first region whose block count is zero ends the list: it and every later region are ignored, and their sector lengths are not checked. With the default layout, offset 0x11FF is the last valid byte and 0x1200 is the first invalid one.
- R2: Elaboration stops with an error in any of these cases:
  - region 0 has no blocks;
  - an active region's sector length is not a power of two, is not a multiple of 256, or is not below 2^24;
  - an active region does not start on a multiple of its own sector length;
  - the total length exceeds 2^ADDR_W.
  
  Every size the block reports is therefore a power of two of at least 256.
- R3: For a valid offset, `sector_idx_o` is the sum of the block counts of all earlier regions plus (offset − region start) / sector length of the region that holds the offset.
- R4: For a valid offset, `sector_size_o` is the sector length of the region that holds the offset.
- R5: For a valid offset, `sector_base_o` is the offset with its low log2(sector length) bits cleared.
- R6: An offset at or beyond the total length sets `range_err_o` to 1. In that case `sector_idx_o`, `sector_size_o`, `sector_base_o` and `erasing_o` are all 0. For a valid offset, `range_err_o` is 0.
- R7: When `mark_i` is high at a rising clock edge, the pending flag of the sector that holds `lookup_offset_i` is set from that edge on. Flags of other sectors are unchanged. `erasing_o` shows the flag of the sector currently looked up, with no added delay.
- R8: When `clear_i` is high at a rising clock edge, every pending flag is 0 after that edge. If `mark_i` is high in the same cycle, the mark is dropped.
- R9: A mark pulse while `range_err_o` is 1 changes no flag.
- R10: While `rst_n` is low, all pending flags are 0, and they stay 0 after reset is released until a mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| lookup_offset_i | input | ADDR_W | Byte offset to locate |
| mark_i | input | 1 | Sets the pending flag of the looked-up sector |
| clear_i | input | 1 | Clears all pending flags; has priority over a mark |
| sector_idx_o | output | IDX_W | Global sector number of the offset |
| sector_size_o | output | ADDR_W+1 | Sector length in bytes, 0 when out of range |
| sector_base_o | output | ADDR_W | Sector-aligned base of the offset |
| range_err_o | output | 1 | Offset lies at or beyond the total length |
| erasing_o | output | 1 | Pending flag of the looked-up sector |

## Verification
A wrong region boundary or a wrong start sector in the decoder shows up at once on the combinational outputs. The index, size or base is off for the offsets next to that boundary, so the bench probes both sides of every region edge and the first invalid offset. A wrong flag only shows up when the matching sector is looked up, one edge after the mark or clear that should have changed it. For this reason the bench sweeps one offset from every sector after each flag operation and compares all nine flags against a map it keeps on its own.

// File: rtl/sloc_pkg.sv
package sloc_pkg;

   localparam int unsigned MAX_REGIONS = 4;

   typedef logic [MAX_REGIONS-1:0][31:0] region_cfg_t;

   // number of regions before the first zero block count
   function automatic int unsigned count_active(region_cfg_t blocks);
      int unsigned n = 0;
      bit          stop = 1'b0;
      for (int r = 0; r < MAX_REGIONS; r++) begin
         if (blocks[r] == 32'd0) stop = 1'b1;
         if (!stop) n++;
      end
      return n;
   endfunction

   // byte address where region r begins
   function automatic longint unsigned region_start(region_cfg_t blocks,
                                                    region_cfg_t lens,
                                                    int r);
      longint unsigned a = 0;
      for (int i = 0; i < MAX_REGIONS; i++)
         if (i < r) a += 64'(blocks[i]) * 64'(lens[i]);
      return a;
   endfunction

   // global number of the first sector of region r
   function automatic int unsigned first_sector(region_cfg_t blocks, int r);
      int unsigned n = 0;
      for (int i = 0; i < MAX_REGIONS; i++)
         if (i < r) n += blocks[i];
      return n;
   endfunction

   function automatic bit is_pow2(longint unsigned x);
      return (x != 0) && ((x & (x - 1)) == 0);
   endfunction

   function automatic bit legal_len(longint unsigned x);
      return is_pow2(x) && ((x & 64'hFF) == 0) && (x < (64'd1 << 24));
   endfunction

   function automatic int unsigned log2_exact(longint unsigned x);
      int unsigned k = 0;
      for (int b = 0; b < 64; b++)
         if (x[b]) k = b;
      return k;
   endfunction

endpackage

// File: rtl/sloc_region_match.sv
module sloc_region_match #(
   parameter int unsigned     ADDR_W    = 16,
   parameter int unsigned     IDX_W     = 4,
   parameter longint unsigned START     = 0,
   parameter int unsigned     LEN_LOG2  = 8,
   parameter int unsigned     BLOCKS    = 1,
   parameter int unsigned     FIRST_SEC = 0
) (
   input  logic [ADDR_W-1:0] offset_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [ADDR_W:0]   size_o,
   output logic [ADDR_W-1:0] base_o
);
   localparam int unsigned     EXT_W = ADDR_W + 1;
   localparam longint unsigned SPAN  = 64'(BLOCKS) << LEN_LOG2;
   localparam logic [EXT_W-1:0] LO   = EXT_W'(START);
   localparam logic [EXT_W-1:0] HI   = EXT_W'(START + SPAN);
   localparam logic [EXT_W-1:0] ONE_SECTOR = EXT_W'(64'd1 << LEN_LOG2);
   localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'((64'd1 << LEN_LOG2) - 64'd1);

   logic [EXT_W-1:0] off_ext;
   logic [EXT_W-1:0] rel;

   assign off_ext = {1'b0, offset_i};
   assign rel     = off_ext - LO;
   assign hit_o   = (off_ext >= LO) && (off_ext < HI);
   assign idx_o   = IDX_W'(FIRST_SEC) + IDX_W'(rel >> LEN_LOG2);
   assign size_o  = ONE_SECTOR;
   assign base_o  = offset_i & ~LOW_MASK;

endmodule

// File: rtl/sloc_select.sv
module sloc_select #(
   parameter int unsigned N      = 4,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 4
) (
   input  logic [N-1:0]             hit_i,
   input  logic [N-1:0][IDX_W-1:0]  idx_i,
   input  logic [N-1:0][ADDR_W:0]   size_i,
   input  logic [N-1:0][ADDR_W-1:0] base_i,
   output logic                     found_o,
   output logic [IDX_W-1:0]         idx_o,
   output logic [ADDR_W:0]          size_o,
   output logic [ADDR_W-1:0]        base_o
);
   // regions never overlap, so an AND-OR merge is enough
   always_comb begin
      found_o = |hit_i;
      idx_o   = '0;
      size_o  = '0;
      base_o  = '0;
      for (int r = 0; r < N; r++) begin
         if (hit_i[r]) begin
            idx_o  = idx_o  | idx_i[r];
            size_o = size_o | size_i[r];
            base_o = base_o | base_i[r];
         end
      end
   end

endmodule

// File: rtl/sloc_erase_map.sv
module sloc_erase_map #(
   parameter int unsigned N_SEC = 9,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mark_i,
   input  logic             clear_i,
   input  logic             sel_valid_i,
   input  logic [IDX_W-1:0] sel_idx_i,
   output logic             pending_o
);
   logic [N_SEC-1:0] map_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= '0;
      end else if (clear_i) begin
         map_q <= '0;
      end else if (mark_i && sel_valid_i) begin
         for (int s = 0; s < N_SEC; s++)
            if (sel_idx_i == IDX_W'(s)) map_q[s] <= 1'b1;
      end
   end

   always_comb begin
      pending_o = 1'b0;
      for (int s = 0; s < N_SEC; s++)
         if (sel_valid_i && (sel_idx_i == IDX_W'(s))) pending_o = map_q[s];
   end

endmodule

// File: rtl/sector_locator.sv
module sector_locator
   import sloc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter region_cfg_t REG_BLOCKS = {32'd0, 32'd3, 32'd2, 32'd4},
   parameter region_cfg_t REG_LEN    = {32'd100, 32'd512, 32'd1024, 32'd256},
   localparam int unsigned     N_ACT    = count_active(REG_BLOCKS),
   localparam longint unsigned CHIP_LEN = region_start(REG_BLOCKS, REG_LEN, N_ACT),
   localparam int unsigned     N_SEC    = first_sector(REG_BLOCKS, N_ACT),
   localparam int unsigned     IDX_W    = (N_SEC > 1) ? $clog2(N_SEC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lookup_offset_i,
   input  logic              mark_i,
   input  logic              clear_i,
   output logic [IDX_W-1:0]  sector_idx_o,
   output logic [ADDR_W:0]   sector_size_o,
   output logic [ADDR_W-1:0] sector_base_o,
   output logic              range_err_o,
   output logic              erasing_o
);

   // R2: layout checks at elaboration
   if (N_ACT == 0) begin : g_chk_empty
      $error("sector_locator: region 0 has no blocks");
   end
   if (CHIP_LEN > (64'd1 << ADDR_W)) begin : g_chk_fit
      $error("sector_locator: layout longer than the address space");
   end

   logic [MAX_REGIONS-1:0]             hit;
   logic [MAX_REGIONS-1:0][IDX_W-1:0]  r_idx;
   logic [MAX_REGIONS-1:0][ADDR_W:0]   r_size;
   logic [MAX_REGIONS-1:0][ADDR_W-1:0] r_base;

   for (genvar r = 0; r < MAX_REGIONS; r++) begin : g_region
      if (r < N_ACT) begin : g_on
         localparam longint unsigned START = region_start(REG_BLOCKS, REG_LEN, r);
         localparam longint unsigned LEN   = 64'(REG_LEN[r]);
         localparam int unsigned     LG    = log2_exact(LEN);

         if (!legal_len(LEN)) begin : g_chk_len
            $error("sector_locator: illegal sector length in an active region");
         end
         if ((START & (LEN - 1)) != 0) begin : g_chk_align
            $error("sector_locator: region start not aligned to its sector length");
         end
         if (LG > ADDR_W) begin : g_chk_lg
            $error("sector_locator: sector wider than the address space");
         end

         sloc_region_match #(
            .ADDR_W    (ADDR_W),
            .IDX_W     (IDX_W),
            .START     (START),
            .LEN_LOG2  (LG),
            .BLOCKS    (REG_BLOCKS[r]),
            .FIRST_SEC (first_sector(REG_BLOCKS, r))
         ) u_match (
            .offset_i (lookup_offset_i),
            .hit_o    (hit[r]),
            .idx_o    (r_idx[r]),
            .size_o   (r_size[r]),
            .base_o   (r_base[r])
         );
      end else begin : g_off
         assign hit[r]    = 1'b0;
         assign r_idx[r]  = '0;
         assign r_size[r] = '0;
         assign r_base[r] = '0;
      end
   end

   logic found;

   sloc_select #(
      .N      (MAX_REGIONS),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_select (
      .hit_i   (hit),
      .idx_i   (r_idx),
      .size_i  (r_size),
      .base_i  (r_base),
      .found_o (found),
      .idx_o   (sector_idx_o),
      .size_o  (sector_size_o),
      .base_o  (sector_base_o)
   );

   assign range_err_o = ~found;

   sloc_erase_map #(
      .N_SEC (N_SEC),
      .IDX_W (IDX_W)
   ) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .mark_i      (mark_i),
      .clear_i     (clear_i),
      .sel_valid_i (found),
      .sel_idx_i   (sector_idx_o),
      .pending_o   (erasing_o)
   );

endmodule

// File: rtl/sloc_checker.sv
module sloc_checker #(
   parameter int unsigned     ADDR_W   = 16,
   parameter int unsigned     IDX_W    = 4,
   parameter longint unsigned CHIP_LEN = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] lookup_offset_i,
   input logic              mark_i,
   input logic              clear_i,
   input logic [IDX_W-1:0]  sector_idx_o,
   input logic [ADDR_W:0]   sector_size_o,
   input logic [ADDR_W-1:0] sector_base_o,
   input logic              range_err_o,
   input logic              erasing_o
);
   localparam int unsigned      EXT_W = ADDR_W + 1;
   localparam logic [EXT_W-1:0] LIMIT = EXT_W'(CHIP_LEN);

   logic [EXT_W-1:0] off_x, base_x;
   assign off_x  = {1'b0, lookup_offset_i};
   assign base_x = {1'b0, sector_base_o};

   a_r6_err_beyond_chip: assert property (@(posedge clk) disable iff (!rst_n)
      range_err_o == (off_x >= LIMIT));

   a_r6_err_zero_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      range_err_o |-> (sector_idx_o == '0 && sector_size_o == '0 &&
                       sector_base_o == '0 && !erasing_o));

   a_r4_size_pow2: assert property (@(posedge clk) disable iff (!rst_n)
      !range_err_o |-> ($countones(sector_size_o) == 1 && sector_size_o >= EXT_W'(256)));

   a_r5_base_window: assert property (@(posedge clk) disable iff (!rst_n)
      !range_err_o |-> (((base_x & (sector_size_o - EXT_W'(1))) == '0) &&
                        (base_x <= off_x) && ((off_x - base_x) < sector_size_o)));

   a_r7_mark_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_i && !clear_i && !range_err_o) |=> ($stable(lookup_offset_i) -> erasing_o));

   a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !erasing_o);

   a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!mark_i && !clear_i) |=> ($stable(lookup_offset_i) -> $stable(erasing_o)));

endmodule

bind sector_locator sloc_checker #(
   .ADDR_W   (ADDR_W),
   .IDX_W    (IDX_W),
   .CHIP_LEN (CHIP_LEN)
) u_sloc_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .lookup_offset_i (lookup_offset_i),
   .mark_i          (mark_i),
   .clear_i         (clear_i),
   .sector_idx_o    (sector_idx_o),
   .sector_size_o   (sector_size_o),
   .sector_base_o   (sector_base_o),
   .range_err_o     (range_err_o),
   .erasing_o       (erasing_o)
);

// File: tb/tb_sector_locator.sv
module tb_sector_locator;
   localparam int CLK_PERIOD = 10;
   localparam int N_SEC      = 9;
   localparam int N_VEC      = 13;

   typedef struct packed {
      logic [15:0] off;
      logic [3:0]  idx;
      logic [16:0] size;
      logic [15:0] base;
      logic        err;
   } vec_t;

   // default layout: 4 x 256 B, 2 x 1 KiB, 3 x 512 B, fourth region empty
   localparam vec_t VECS [N_VEC] = '{
      '{16'h0000, 4'd0, 17'h00100, 16'h0000, 1'b0},
      '{16'h00FF, 4'd0, 17'h00100, 16'h0000, 1'b0},
      '{16'h0100, 4'd1, 17'h00100, 16'h0100, 1'b0},
      '{16'h03FF, 4'd3, 17'h00100, 16'h0300, 1'b0},
      '{16'h0400, 4'd4, 17'h00400, 16'h0400, 1'b0},
      '{16'h07FF, 4'd4, 17'h00400, 16'h0400, 1'b0},
      '{16'h0800, 4'd5, 17'h00400, 16'h0800, 1'b0},
      '{16'h0BFF, 4'd5, 17'h00400, 16'h0800, 1'b0},
      '{16'h0C00, 4'd6, 17'h00200, 16'h0C00, 1'b0},
      '{16'h0E10, 4'd7, 17'h00200, 16'h0E00, 1'b0},
      '{16'h11FF, 4'd8, 17'h00200, 16'h1000, 1'b0},
      '{16'h1200, 4'd0, 17'h00000, 16'h0000, 1'b1},
      '{16'hFFFF, 4'd0, 17'h00000, 16'h0000, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] lookup_offset_i = '0;
   logic        mark_i = 1'b0;
   logic        clear_i = 1'b0;
   logic [3:0]  sector_idx_o;
   logic [16:0] sector_size_o;
   logic [15:0] sector_base_o;
   logic        range_err_o;
   logic        erasing_o;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sector_locator dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .lookup_offset_i (lookup_offset_i),
      .mark_i          (mark_i),
      .clear_i         (clear_i),
      .sector_idx_o    (sector_idx_o),
      .sector_size_o   (sector_size_o),
      .sector_base_o   (sector_base_o),
      .range_err_o     (range_err_o),
      .erasing_o       (erasing_o)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rep_off(input int s);
      case (s)
         0: return 16'h0000;  1: return 16'h0100;  2: return 16'h0200;
         3: return 16'h0300;  4: return 16'h0400;  5: return 16'h0800;
         6: return 16'h0C00;  7: return 16'h0E00;  default: return 16'h1000;
      endcase
   endfunction

   task automatic scan_map(input logic [N_SEC-1:0] exp_map, input string req);
      for (int s = 0; s < N_SEC; s++) begin
         @(negedge clk);
         lookup_offset_i = rep_off(s);
         #1;
         chk({31'b0, erasing_o}, {31'b0, exp_map[s]}, req, $sformatf("flag of sector %0d", s));
      end
   endtask

   task automatic do_cmd(input logic [15:0] off, input logic m, input logic c);
      @(negedge clk);
      lookup_offset_i = off;
      mark_i  = m;
      clear_i = c;
      @(negedge clk);
      mark_i  = 1'b0;
      clear_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      // R10: flags low while reset is held
      repeat (2) @(negedge clk);
      lookup_offset_i = 16'h0800;
      #1;
      chk({31'b0, erasing_o}, 32'd0, "R10", "flag during reset");
      @(negedge clk);
      rst_n = 1'b1;
      scan_map(9'h000, "R10");

      // R1 R3 R4 R5 R6 via the vector table
      for (int v = 0; v < N_VEC; v++) begin
         @(negedge clk);
         lookup_offset_i = VECS[v].off;
         #1;
         chk({28'b0, sector_idx_o},  {28'b0, VECS[v].idx},  "R3", $sformatf("index @%0h", VECS[v].off));
         chk({15'b0, sector_size_o}, {15'b0, VECS[v].size}, "R4", $sformatf("size @%0h", VECS[v].off));
         chk({16'b0, sector_base_o}, {16'b0, VECS[v].base}, "R5", $sformatf("base @%0h", VECS[v].off));
         chk({31'b0, range_err_o},   {31'b0, VECS[v].err},  "R6", $sformatf("range error @%0h", VECS[v].off));
         // R2: any reported size is a multiple of 256
         chk({24'b0, sector_size_o[7:0]}, 32'd0, "R2", "size low byte");
      end
      // R1: last valid byte and first byte past the terminated list
      @(negedge clk); lookup_offset_i = 16'h11FF; #1;
      chk({31'b0, range_err_o}, 32'd0, "R1", "last byte of region 2");
      @(negedge clk); lookup_offset_i = 16'h1200; #1;
      chk({31'b0, range_err_o}, 32'd1, "R1", "first byte after list end");

      // R7: mark sector 5, then sector 0
      do_cmd(16'h0900, 1'b1, 1'b0);
      scan_map(9'b000100000, "R7");
      do_cmd(16'h00A0, 1'b1, 1'b0);
      scan_map(9'b000100001, "R7");

      // R9: mark outside the array changes nothing
      do_cmd(16'h1300, 1'b1, 1'b0);
      @(negedge clk); lookup_offset_i = 16'h1300; #1;
      chk({31'b0, erasing_o}, 32'd0, "R9", "flag while out of range");
      scan_map(9'b000100001, "R9");

      // R8: clear beats a simultaneous mark
      do_cmd(16'h0C00, 1'b1, 1'b1);
      scan_map(9'h000, "R8");

      // R10: reset in mid-run drops a pending flag
      do_cmd(16'h1000, 1'b1, 1'b0);
      scan_map(9'b100000000, "R7");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      scan_map(9'h000, "R10");

      done = 1'b1;
      finish_run();
   end

endmodule